// File: doc/BRIEF.md
# Basic Block Loop Sequencer

This block runs one basic block at a time on behalf of a bundle executor. A block header arrives on a valid/ready port. It carries the number of bundles in the block, an optional repeat count, and the fall-through program counter. The repeat count is either an immediate or the index of a register whose value is fetched through a combinational read port. The sequencer then hands bundle indices, in ascending order, to the executor over a valid/ready issue port. It also counts the completion pulses that come back. The header port stalls (ready low) while a block is in progress. The issue port holds its index stable while the executor withholds ready.

A completion may report a taken branch with a target. The target is only recorded at that point. Every bundle of the declared size still runs, and every requested repetition still runs. When the last completion of the last pass arrives, the sequencer raises a one-cycle done pulse with the next program counter. That value is the target of the last taken branch seen in the whole block, or the fall-through address if no branch was taken. Because the header can request repetition, a loop needs no branch instruction.

Top module: `bb_loop_seq`

## Requirements
- R1: `hdr_ready` is high only while no block is active. A header is taken on a cycle with `hdr_valid` and `hdr_ready` both high. `hdr_ready` stays low from that cycle until the cycle after the `block_done` pulse.
- R2: `hdr_nbm1` holds the bundle count minus one, so a block has 1 to 8 bundles. In each pass, indices 0 up to `hdr_nbm1` are issued once each, in ascending order.
- R3: Once `iss_valid` is high, it stays high with `iss_idx` unchanged until a cycle in which `iss_ready` is high.
- R4: If `hdr_loop` is 0, the block makes exactly one pass. If `hdr_loop` is 1, the pass count is `hdr_count` when `hdr_use_reg` is 0. When `hdr_use_reg` is 1, the pass count is `rf_data`, read at acceptance from register index `rf_idx`, which equals `hdr_count`.
- R5: A register-sourced count is read only in the acceptance cycle. Changing `rf_data` afterwards does not change the number of passes.
- R6: A pass count of zero issues no bundle. `block_done` then rises in the cycle right after acceptance, with `next_pc` equal to `hdr_fall_pc`.
- R7: A taken branch does not cut the block short. `next_pc` is the target of the last taken completion over all passes of the block, or `hdr_fall_pc` if no completion reported a taken branch.
- R8: `block_done` is a single-cycle pulse with `next_pc` valid. It comes in the cycle after the final completion of the final pass.
- R9: Completions that arrive while no block is running, or that exceed the bundles issued so far, are ignored.
- R10: With `iss_ready` held high, each pass takes `hdr_nbm1 + 2` cycles. So `block_done` rises passes × (`hdr_nbm1` + 2) clock edges after the acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header offered |
| hdr_ready | output | 1 | Sequencer idle, header can be taken |
| hdr_nbm1 | input | NB_W | Bundle count minus one |
| hdr_loop | input | 1 | Repeat count present |
| hdr_use_reg | input | 1 | Count field is a register index |
| hdr_count | input | CNT_W | Immediate count or register index |
| hdr_fall_pc | input | PC_W | Fall-through program counter |
| rf_idx | output | CNT_W | Register read index |
| rf_data | input | CNT_W | Register read value |
| iss_valid | output | 1 | Bundle index offered to executor |
| iss_ready | input | 1 | Executor takes the index |
| iss_idx | output | NB_W | Bundle index within the block |
| cmp_valid | input | 1 | One bundle completed |
| cmp_taken | input | 1 | Completed bundle resolved a taken branch |
| cmp_target | input | PC_W | Branch target of that bundle |
| block_done | output | 1 | One-cycle end-of-block pulse |
| next_pc | output | PC_W | Program counter to continue at |

## Verification
The block is driven with one-pass blocks of 1, 2, 4 and 8 bundles, immediate repeat counts of 2, 3 and 5, and register-sourced counts. These patterns separate a wrong pass count from a wrong bundle count: the total issue count and the done latency each depend on both. Branch masks include a single early branch, several branches in one pass (the later one must win), and branch flags on bundle numbers beyond the block size (these must never be issued). Zero counts from both sources and a register change after acceptance test the entry rules. A stalling executor tests index hold. A stray taken completion while idle must not leak into the next block's `next_pc`.

// File: rtl/bb_loop_seq_pkg.sv
package bb_loop_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/bb_iter_ctr.sv
// Remaining-pass counter: loaded once at block entry, stepped at each pass end.
module bb_iter_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic             last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    left_q <= '0;
    else if (load) left_q <= load_val;
    else if (step) left_q <= left_q - ONE;
  end

  assign last = (left_q == ONE);
endmodule

// File: rtl/bb_pass_track.sv
// Issues bundle indices of one pass and counts the completions that come back.
module bb_pass_track #(
  parameter int NB_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [NB_W-1:0] nbm1_in,
  input  logic            run,
  input  logic            iss_ready,
  input  logic            cmp_valid,
  output logic            iss_valid,
  output logic [NB_W-1:0] iss_idx,
  output logic            cmp_ok,
  output logic            pass_end
);
  localparam int IC_W = NB_W + 1;

  logic [NB_W-1:0] nbm1_q;
  logic [IC_W-1:0] iss_cnt;
  logic [NB_W-1:0] cmp_cnt;
  logic            all_issued;

  assign all_issued = iss_cnt > {1'b0, nbm1_q};
  assign iss_valid  = run && !all_issued;
  assign iss_idx    = iss_cnt[NB_W-1:0];
  assign cmp_ok     = run && cmp_valid && ({1'b0, cmp_cnt} < iss_cnt);
  assign pass_end   = cmp_ok && (cmp_cnt == nbm1_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nbm1_q  <= '0;
      iss_cnt <= '0;
      cmp_cnt <= '0;
    end else if (load) begin
      nbm1_q  <= nbm1_in;
      iss_cnt <= '0;
      cmp_cnt <= '0;
    end else if (pass_end) begin
      iss_cnt <= '0;
      cmp_cnt <= '0;
    end else begin
      if (iss_valid && iss_ready) iss_cnt <= iss_cnt + IC_W'(1);
      if (cmp_ok)                 cmp_cnt <= cmp_cnt + NB_W'(1);
    end
  end
endmodule

// File: rtl/bb_branch_rec.sv
// Holds the latest taken branch target; the live completion overrides the held one.
module bb_branch_rec #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            hit,
  input  logic [PC_W-1:0] tgt,
  output logic            eff_taken,
  output logic [PC_W-1:0] eff_tgt
);
  logic            taken_q;
  logic [PC_W-1:0] tgt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken_q <= 1'b0;
      tgt_q   <= '0;
    end else if (clear) begin
      taken_q <= 1'b0;
      tgt_q   <= '0;
    end else if (hit) begin
      taken_q <= 1'b1;
      tgt_q   <= tgt;
    end
  end

  assign eff_taken = taken_q || hit;
  assign eff_tgt   = hit ? tgt : tgt_q;
endmodule

// File: rtl/bb_loop_seq.sv
module bb_loop_seq
  import bb_loop_seq_pkg::*;
#(
  parameter int NB_W  = 3,
  parameter int CNT_W = 8,
  parameter int PC_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_valid,
  output logic             hdr_ready,
  input  logic [NB_W-1:0]  hdr_nbm1,
  input  logic             hdr_loop,
  input  logic             hdr_use_reg,
  input  logic [CNT_W-1:0] hdr_count,
  input  logic [PC_W-1:0]  hdr_fall_pc,
  output logic [CNT_W-1:0] rf_idx,
  input  logic [CNT_W-1:0] rf_data,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [NB_W-1:0]  iss_idx,
  input  logic             cmp_valid,
  input  logic             cmp_taken,
  input  logic [PC_W-1:0]  cmp_target,
  output logic             block_done,
  output logic [PC_W-1:0]  next_pc
);
  seq_state_t       st;
  logic             hdr_fire, run, last, pass_end, cmp_ok, eff_taken;
  logic [CNT_W-1:0] start_cnt;
  logic [PC_W-1:0]  fall_q, eff_tgt;

  assign hdr_ready  = (st == ST_IDLE);
  assign hdr_fire   = hdr_valid && hdr_ready;
  assign run        = (st == ST_RUN);
  assign block_done = (st == ST_DONE);
  assign rf_idx     = hdr_count;
  assign start_cnt  = !hdr_loop   ? CNT_W'(1) :
                      hdr_use_reg ? rf_data   : hdr_count;

  bb_iter_ctr #(.CNT_W(CNT_W)) u_iter (
    .clk(clk), .rst_n(rst_n), .load(hdr_fire), .load_val(start_cnt),
    .step(pass_end && !last), .last(last)
  );

  bb_pass_track #(.NB_W(NB_W)) u_pass (
    .clk(clk), .rst_n(rst_n), .load(hdr_fire), .nbm1_in(hdr_nbm1),
    .run(run), .iss_ready(iss_ready), .cmp_valid(cmp_valid),
    .iss_valid(iss_valid), .iss_idx(iss_idx), .cmp_ok(cmp_ok),
    .pass_end(pass_end)
  );

  bb_branch_rec #(.PC_W(PC_W)) u_br (
    .clk(clk), .rst_n(rst_n), .clear(hdr_fire), .hit(cmp_ok && cmp_taken),
    .tgt(cmp_target), .eff_taken(eff_taken), .eff_tgt(eff_tgt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      fall_q  <= '0;
      next_pc <= '0;
    end else begin
      case (st)
        ST_IDLE: if (hdr_fire) begin
          fall_q <= hdr_fall_pc;
          if (start_cnt == '0) begin
            st      <= ST_DONE;
            next_pc <= hdr_fall_pc;
          end else begin
            st <= ST_RUN;
          end
        end
        ST_RUN: if (pass_end && last) begin
          st      <= ST_DONE;
          next_pc <= eff_taken ? eff_tgt : fall_q;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bb_loop_seq_chk.sv
module bb_loop_seq_chk #(
  parameter int NB_W  = 3,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hdr_valid,
  input logic             hdr_ready,
  input logic             hdr_loop,
  input logic             hdr_use_reg,
  input logic [CNT_W-1:0] hdr_count,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [NB_W-1:0]  iss_idx,
  input logic             block_done
);
  logic imm_zero_take;
  assign imm_zero_take = hdr_valid && hdr_ready && hdr_loop && !hdr_use_reg
                         && (hdr_count == '0);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |=> !block_done);

  assert_issue_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_idx)));

  assert_busy_no_hdr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid || block_done) |-> !hdr_ready);

  assert_zero_skip_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    imm_zero_take |=> (block_done && !iss_valid));

  assert_pass_starts_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iss_valid) |-> (iss_idx == '0));
endmodule

bind bb_loop_seq bb_loop_seq_chk #(.NB_W(NB_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/bb_loop_seq_test.sv
module bb_loop_seq_test;
  localparam int NV = 10;
  localparam logic [7:0] REG_IX = 8'h2A;
  // [2:0] nbm1, [3] loop, [4] use_reg, [5] stall, [15:8] count, [23:16] branch mask, [31:24] reg value
  localparam logic [31:0] VEC [NV] = '{
    {8'd0, 8'h00, 8'd0,   8'b00000000},  // 1 bundle, one pass
    {8'd0, 8'h01, 8'd0,   8'b00000011},  // 4 bundles, early branch
    {8'd0, 8'h00, 8'd3,   8'b00001111},  // 8 bundles x3
    {8'd0, 8'h06, 8'd5,   8'b00001010},  // 3 bundles x5, two branches
    {8'd4, 8'h00, REG_IX, 8'b00011001},  // reg count 4
    {8'd0, 8'hFF, 8'd0,   8'b00001100},  // imm zero
    {8'd0, 8'h28, 8'd2,   8'b00101101},  // stall, 6 bundles x2
    {8'd0, 8'h03, REG_IX, 8'b00011010},  // reg count 0
    {8'd0, 8'h80, 8'd0,   8'b00000111},  // 8 bundles, last branches
    {8'd0, 8'h0C, 8'd0,   8'b00000001}   // mask beyond block size
  };

  logic clk = 0, rst_n = 0;
  logic hdr_valid = 0, hdr_loop = 0, hdr_use_reg = 0, iss_ready = 1;
  logic [2:0] hdr_nbm1 = 0;
  logic [7:0] hdr_count = 0, rf_idx, reg_val = 0, rf_data;
  logic [15:0] hdr_fall_pc = 0, tgt_base = 16'h8000, cmp_target, next_pc;
  logic hdr_ready, iss_valid, block_done, cmp_valid, cmp_taken;
  logic [2:0] iss_idx;
  logic pend = 0, spur = 0, stall = 0;
  logic [2:0] pend_idx = 0;
  logic [7:0] mask_cur = 0;
  int checks = 0, fails = 0, issues = 0, idx_err = 0, exp_idx = 0, cur_nb = 1, cyc = 0;

  always #2.5 clk = ~clk;

  assign rf_data    = (rf_idx == REG_IX) ? reg_val : 8'h77;
  assign cmp_valid  = pend | spur;
  assign cmp_taken  = (pend && mask_cur[pend_idx]) | spur;
  assign cmp_target = spur ? 16'hDEAD : tgt_base + 16'(pend_idx) * 16'd4;

  bb_loop_seq uut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    pend <= iss_valid && iss_ready;
    pend_idx <= iss_idx;
    if (iss_valid && iss_ready) begin
      issues <= issues + 1;
      if (int'(iss_idx) != exp_idx) idx_err <= idx_err + 1;
      exp_idx <= (exp_idx + 1 == cur_nb) ? 0 : exp_idx + 1;
    end
  end
  always @(negedge clk) iss_ready <= stall ? cyc[0] : 1'b1;

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [31:0] v, input int vi, input bit poke);
    int n, nb, hi, cycles;
    nb = int'(v[2:0]) + 1;
    n  = !v[3] ? 1 : (v[4] ? int'(v[31:24]) : int'(v[15:8]));
    hi = -1;
    if (n > 0) for (int b = 0; b < nb; b++) if (v[16+b]) hi = b;
    @(negedge clk);
    hdr_nbm1 = v[2:0]; hdr_loop = v[3]; hdr_use_reg = v[4]; hdr_count = v[15:8];
    reg_val = v[31:24]; mask_cur = v[23:16]; stall = v[5];
    hdr_fall_pc = 16'h1000 + 16'(vi) * 16'd16;
    tgt_base = 16'h8000 + 16'(vi) * 16'd256;
    cur_nb = nb; exp_idx = 0; issues = 0; idx_err = 0;
    chk(hdr_ready == 1'b1, "R1 ready idle", hdr_ready, 1);
    hdr_valid = 1;
    @(posedge clk);
    @(negedge clk);
    hdr_valid = 0;
    if (poke) reg_val = 8'd9;
    chk(hdr_ready == 1'b0, "R1 busy", hdr_ready, 0);
    cycles = 0;
    while (!block_done && cycles < 2000) begin
      @(posedge clk); cycles++; @(negedge clk);
    end
    chk(next_pc == (hi < 0 ? hdr_fall_pc : tgt_base + 16'(hi) * 16'd4),
        "R7 next_pc", next_pc, hi < 0 ? hdr_fall_pc : tgt_base + 16'(hi) * 16'd4);
    chk(issues == n * nb, poke ? "R5 passes" : "R4 R6 issues", issues, n * nb);
    chk(idx_err == 0, "R2 order", idx_err, 0);
    if (!stall) chk(cycles == n * (nb + 1), "R10 R8 latency", cycles, n * (nb + 1));
    @(negedge clk);
    chk(block_done == 1'b0 && hdr_ready == 1'b1, "R8 R1 pulse", block_done, 0);
    stall = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(hdr_ready && !block_done && !iss_valid, "R1 reset", {hdr_ready, block_done, iss_valid}, 3'b100);
    for (int i = 0; i < NV; i++) run_vec(VEC[i], i, 1'b0);
    // R5: register changes after acceptance
    run_vec({8'd3, 8'h00, REG_IX, 8'b00011000}, 11, 1'b1);
    // R9: stray taken completion while idle must not redirect the next block
    @(negedge clk); spur = 1; @(negedge clk); spur = 0;
    chk(block_done == 1'b0, "R9 idle stray", block_done, 0);
    run_vec({8'd0, 8'h00, 8'd0, 8'b00000001}, 12, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule